// File: doc/BRIEF.md
# Reset Source Controller

This block gathers every reason a small microcontroller core may need to be reset and turns them into one sequenced internal reset. A power-on event starts a long recovery count. A watchdog overflow, an illegal instruction, a STOP instruction while STOP is not allowed, an opcode fetch from an unmapped address, and a low level on the external reset pin each start a shorter reset. Each source is qualified by configuration bits and, for the address check, by the bus cycle type.

Each accepted reset writes a one-hot cause into a status register. Software reads and clears that register after restart. For internal causes the block pulls the external reset pin low for a fixed window, so that other devices on the board follow the core. Every reset ends with a two-cycle reset-vector fetch at the top two addresses of the map. Normal running then resumes.

Top module: `reset_source_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst` is 1, `pin_pull` is 0 and `stat` is 5'b00001. Status bit 0 is power-on, bit 1 is watchdog, bit 2 is illegal opcode, bit 3 is illegal address and bit 4 is external pin.
- R2: After `por_n` rises, `core_rst` stays 1 for exactly POR_CYC + 2*PH_CYC clock cycles (default 4096 + 32 + 32).
- R3: When a reset ends, `vec_fetch` is 1 for two cycles, with `vec_addr` 16'hFFFE and then 16'hFFFF. `core_rst` is 0 in both cycles. `vec_fetch` then returns to 0.
- R4: A `wdog_ovf` strobe while running resets the core and leaves `stat` at 5'b00010, but only if `cfg_wdog_off` is 0. With `cfg_wdog_off` at 1 it has no effect.
- R5: A `cpu_bad_op` strobe while running resets the core and leaves `stat` at 5'b00100.
- R6: A `cpu_stop_op` strobe resets the core with `stat` 5'b00100 when `cfg_stop_en` is 0. It has no effect when `cfg_stop_en` is 1.
- R7: A bus cycle (`bus_cyc`=1) with `map_hit`=0 resets the core with `stat` 5'b01000 only when `bus_opfetch` is 1. A data access to an unmapped address, or an opcode fetch from a mapped address, has no effect.
- R8: For every internal cause (R4 to R7), `pin_pull` and `core_rst` are both 1 for exactly PIN_CYC cycles (default 32), starting the cycle after the strobe. The vector fetch follows.
- R9: `ext_rst_n` low while running sets `stat` to 5'b10000 and holds `core_rst` at 1 with `pin_pull` 0 until the pin returns high. The vector fetch follows on the next cycle.
- R10: In the cycle `stat_rd` is 1, `stat` still shows the recorded cause. In the following cycle `stat` is 0, unless a new cause is latched in that same cycle.
- R11: Reset requests that arrive while a reset or vector fetch is in progress are ignored. They change neither `stat` nor the length of the pin window.
- R12: When several causes arrive in the same cycle, only one flag is set. The priority is watchdog, then illegal opcode, then illegal address, then external pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| cfg_wdog_off | input | 1 | 1 disables watchdog resets |
| cfg_stop_en | input | 1 | 1 allows STOP; 0 makes STOP illegal |
| wdog_ovf | input | 1 | Watchdog overflow strobe |
| cpu_bad_op | input | 1 | CPU decode: illegal instruction strobe |
| cpu_stop_op | input | 1 | CPU decode: STOP instruction strobe |
| bus_cyc | input | 1 | A bus access is active this cycle |
| bus_opfetch | input | 1 | 1 = opcode fetch, 0 = data access |
| map_hit | input | 1 | Address decoder: access falls in a mapped region |
| ext_rst_n | input | 1 | Level of the external reset pin |
| stat_rd | input | 1 | Status read strobe (clears on read) |
| core_rst | output | 1 | Internal reset to the core, active high |
| pin_pull | output | 1 | 1 = pull external reset pin low |
| vec_fetch | output | 1 | Reset-vector fetch cycle |
| vec_addr | output | AW | Vector address during vec_fetch, 0 otherwise |
| stat | output | 5 | One-hot reset cause |

## Verification
Each cause is driven alone while running, and then again with the qualifying input flipped: the watchdog with the disable bit set and clear, and STOP with stop allowed and not allowed. Bus cycles are tried as a data access to an unmapped address, an opcode fetch from a mapped address, and an opcode fetch from an unmapped address, which separates cycle-type qualification from plain address decoding. Bundles of simultaneous strobes expose the priority order. Strobes fired in the middle of a pin window show whether an ongoing reset ignores new requests or restarts on them.

// File: rtl/reset_source_ctrl_pkg.sv
package reset_source_ctrl_pkg;

    localparam int CAUSE_W = 5;

    localparam int CZ_POR  = 0;
    localparam int CZ_WDOG = 1;
    localparam int CZ_OP   = 2;
    localparam int CZ_ADDR = 3;
    localparam int CZ_EXT  = 4;

    typedef enum logic [2:0] {
        ST_POR = 3'd0,   // oscillator settle count
        ST_PHA = 3'd1,   // first recovery phase
        ST_PHB = 3'd2,   // second recovery phase
        ST_PIN = 3'd3,   // internal cause, pin pulled low
        ST_EXT = 3'd4,   // external pin held low
        ST_VLO = 3'd5,   // vector fetch, low byte address
        ST_VHI = 3'd6,   // vector fetch, high address
        ST_RUN = 3'd7
    } rsc_state_e;

endpackage

// File: rtl/reset_source_ctrl_cause.sv
module reset_source_ctrl_cause
    import reset_source_ctrl_pkg::*;
(
    input  logic               accept,
    input  logic               cfg_wdog_off,
    input  logic               cfg_stop_en,
    input  logic               wdog_ovf,
    input  logic               cpu_bad_op,
    input  logic               cpu_stop_op,
    input  logic               bus_cyc,
    input  logic               bus_opfetch,
    input  logic               map_hit,
    input  logic               ext_rst_n,
    output logic               int_req,
    output logic               ext_req,
    output logic [CAUSE_W-1:0] set_mask
);

    logic hit_wdog;
    logic hit_op;
    logic hit_addr;
    logic hit_ext;

    always_comb begin
        hit_wdog = wdog_ovf & ~cfg_wdog_off;
        hit_op   = cpu_bad_op | (cpu_stop_op & ~cfg_stop_en);
        hit_addr = bus_cyc & bus_opfetch & ~map_hit;
        hit_ext  = ~ext_rst_n;

        set_mask = '0;
        if (accept) begin
            if (hit_wdog)      set_mask[CZ_WDOG] = 1'b1;
            else if (hit_op)   set_mask[CZ_OP]   = 1'b1;
            else if (hit_addr) set_mask[CZ_ADDR] = 1'b1;
            else if (hit_ext)  set_mask[CZ_EXT]  = 1'b1;
        end

        int_req = set_mask[CZ_WDOG] | set_mask[CZ_OP] | set_mask[CZ_ADDR];
        ext_req = set_mask[CZ_EXT];
    end

endmodule

// File: rtl/reset_source_ctrl_seq.sv
module reset_source_ctrl_seq
    import reset_source_ctrl_pkg::*;
#(
    parameter int POR_CYC = 4096,
    parameter int PH_CYC  = 32,
    parameter int PIN_CYC = 32,
    parameter int AW      = 16
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          int_req,
    input  logic          ext_req,
    input  logic          ext_low,
    output logic          core_rst,
    output logic          pin_pull,
    output logic          vec_fetch,
    output logic [AW-1:0] vec_addr,
    output logic          accept
);

    localparam int MAX_A = (POR_CYC > PH_CYC) ? POR_CYC : PH_CYC;
    localparam int MAXC  = (MAX_A > PIN_CYC) ? MAX_A : PIN_CYC;
    localparam int CW    = $clog2(MAXC + 1);

    localparam logic [CW-1:0] POR_LAST = CW'(POR_CYC - 1);
    localparam logic [CW-1:0] PH_LAST  = CW'(PH_CYC - 1);
    localparam logic [CW-1:0] PIN_LAST = CW'(PIN_CYC - 1);

    localparam logic [AW-1:0] VEC_HI = '1;
    localparam logic [AW-1:0] VEC_LO = VEC_HI - AW'(1);

    typedef struct packed {
        rsc_state_e      st;
        logic [CW-1:0]   cnt;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_POR: begin
                if (seq_q.cnt == POR_LAST) begin
                    seq_d.st  = ST_PHA;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            ST_PHA: begin
                if (seq_q.cnt == PH_LAST) begin
                    seq_d.st  = ST_PHB;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            ST_PHB: begin
                if (seq_q.cnt == PH_LAST) begin
                    seq_d.st  = ST_VLO;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            ST_PIN: begin
                if (seq_q.cnt == PIN_LAST) begin
                    seq_d.st  = ST_VLO;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            ST_EXT: begin
                if (!ext_low) seq_d.st = ST_VLO;
            end
            ST_VLO: seq_d.st = ST_VHI;
            ST_VHI: seq_d.st = ST_RUN;
            ST_RUN: begin
                seq_d.cnt = '0;
                if (int_req)      seq_d.st = ST_PIN;
                else if (ext_req) seq_d.st = ST_EXT;
            end
            default: seq_d.st = ST_POR;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            seq_q.st  <= ST_POR;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        accept    = (seq_q.st == ST_RUN);
        vec_fetch = (seq_q.st == ST_VLO) || (seq_q.st == ST_VHI);
        core_rst  = !(accept || vec_fetch);
        pin_pull  = (seq_q.st == ST_PIN);
        if (seq_q.st == ST_VLO)      vec_addr = VEC_LO;
        else if (seq_q.st == ST_VHI) vec_addr = VEC_HI;
        else                         vec_addr = '0;
    end

endmodule

// File: rtl/reset_source_ctrl_status.sv
module reset_source_ctrl_status
    import reset_source_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic [CAUSE_W-1:0] set_mask,
    input  logic               stat_rd,
    output logic [CAUSE_W-1:0] stat
);

    localparam logic [CAUSE_W-1:0] POR_VAL = CAUSE_W'(1) << CZ_POR;

    logic [CAUSE_W-1:0] stat_d;
    logic [CAUSE_W-1:0] stat_q;

    always_comb begin
        stat_d = stat_q;
        if (|set_mask)    stat_d = set_mask;
        else if (stat_rd) stat_d = '0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stat_q <= POR_VAL;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;

endmodule

// File: rtl/reset_source_ctrl.sv
module reset_source_ctrl
    import reset_source_ctrl_pkg::*;
#(
    parameter int POR_CYC = 4096,
    parameter int PH_CYC  = 32,
    parameter int PIN_CYC = 32,
    parameter int AW      = 16
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               cfg_wdog_off,
    input  logic               cfg_stop_en,
    input  logic               wdog_ovf,
    input  logic               cpu_bad_op,
    input  logic               cpu_stop_op,
    input  logic               bus_cyc,
    input  logic               bus_opfetch,
    input  logic               map_hit,
    input  logic               ext_rst_n,
    input  logic               stat_rd,
    output logic               core_rst,
    output logic               pin_pull,
    output logic               vec_fetch,
    output logic [AW-1:0]      vec_addr,
    output logic [CAUSE_W-1:0] stat
);

    logic               accept;
    logic               int_req;
    logic               ext_req;
    logic [CAUSE_W-1:0] set_mask;

    reset_source_ctrl_cause u_cause (
        .accept       (accept),
        .cfg_wdog_off (cfg_wdog_off),
        .cfg_stop_en  (cfg_stop_en),
        .wdog_ovf     (wdog_ovf),
        .cpu_bad_op   (cpu_bad_op),
        .cpu_stop_op  (cpu_stop_op),
        .bus_cyc      (bus_cyc),
        .bus_opfetch  (bus_opfetch),
        .map_hit      (map_hit),
        .ext_rst_n    (ext_rst_n),
        .int_req      (int_req),
        .ext_req      (ext_req),
        .set_mask     (set_mask)
    );

    reset_source_ctrl_seq #(
        .POR_CYC (POR_CYC),
        .PH_CYC  (PH_CYC),
        .PIN_CYC (PIN_CYC),
        .AW      (AW)
    ) u_seq (
        .clk       (clk),
        .por_n     (por_n),
        .int_req   (int_req),
        .ext_req   (ext_req),
        .ext_low   (~ext_rst_n),
        .core_rst  (core_rst),
        .pin_pull  (pin_pull),
        .vec_fetch (vec_fetch),
        .vec_addr  (vec_addr),
        .accept    (accept)
    );

    reset_source_ctrl_status u_status (
        .clk      (clk),
        .por_n    (por_n),
        .set_mask (set_mask),
        .stat_rd  (stat_rd),
        .stat     (stat)
    );

endmodule

// File: rtl/reset_source_ctrl_chk.sv
module reset_source_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          por_n,
    input logic          cfg_wdog_off,
    input logic          wdog_ovf,
    input logic          cpu_bad_op,
    input logic          cpu_stop_op,
    input logic          bus_cyc,
    input logic          bus_opfetch,
    input logic          map_hit,
    input logic          ext_rst_n,
    input logic          stat_rd,
    input logic          core_rst,
    input logic          pin_pull,
    input logic          vec_fetch,
    input logic [AW-1:0] vec_addr,
    input logic [4:0]    stat,
    input logic          accept
);

    localparam logic [AW-1:0] VHI = '1;
    localparam logic [AW-1:0] VLO = VHI - AW'(1);

    // R8: the pin is only pulled while the core is held in reset
    p_pin_in_rst_r8: assert property (@(posedge clk) disable iff (!por_n)
        pin_pull |-> core_rst);

    // R12: never more than one cause flag
    p_one_cause_r12: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(stat));

    // R4: enabled watchdog overflow while running starts a pin reset
    p_wdog_r4: assert property (@(posedge clk) disable iff (!por_n)
        (accept && wdog_ovf && !cfg_wdog_off) |=> (core_rst && pin_pull && stat == 5'b00010));

    // R7: a lone unmapped data access does not reset
    p_data_fetch_r7: assert property (@(posedge clk) disable iff (!por_n)
        (accept && bus_cyc && !bus_opfetch && !map_hit && !wdog_ovf
         && !cpu_bad_op && !cpu_stop_op && ext_rst_n) |=> !core_rst);

    // R10: a read while no cause can latch clears the status
    p_rd_clear_r10: assert property (@(posedge clk) disable iff (!por_n)
        (stat_rd && core_rst) |=> (stat == 5'b00000));

    // R11: during a reset, status only changes by a read
    p_ignore_r11: assert property (@(posedge clk) disable iff (!por_n)
        (core_rst && !stat_rd) |=> $stable(stat));

    // R3: low vector address is followed by the high one
    p_vec_seq_r3: assert property (@(posedge clk) disable iff (!por_n)
        (vec_fetch && vec_addr == VLO) |=> (vec_fetch && vec_addr == VHI && !core_rst));

endmodule

bind reset_source_ctrl reset_source_ctrl_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .cfg_wdog_off (cfg_wdog_off),
    .wdog_ovf     (wdog_ovf),
    .cpu_bad_op   (cpu_bad_op),
    .cpu_stop_op  (cpu_stop_op),
    .bus_cyc      (bus_cyc),
    .bus_opfetch  (bus_opfetch),
    .map_hit      (map_hit),
    .ext_rst_n    (ext_rst_n),
    .stat_rd      (stat_rd),
    .core_rst     (core_rst),
    .pin_pull     (pin_pull),
    .vec_fetch    (vec_fetch),
    .vec_addr     (vec_addr),
    .stat         (stat),
    .accept       (accept)
);

// File: tb/tb_reset_source_ctrl.sv
`timescale 1ns/100ps
module tb_reset_source_ctrl;

    localparam int POR_CYC = 4096;
    localparam int PH_CYC  = 32;
    localparam int PIN_CYC = 32;
    localparam int AW      = 16;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          cfg_wdog_off = 1'b0;
    logic          cfg_stop_en = 1'b1;
    logic          wdog_ovf = 1'b0;
    logic          cpu_bad_op = 1'b0;
    logic          cpu_stop_op = 1'b0;
    logic          bus_cyc = 1'b0;
    logic          bus_opfetch = 1'b0;
    logic          map_hit = 1'b1;
    logic          ext_rst_n = 1'b1;
    logic          stat_rd = 1'b0;
    logic          core_rst;
    logic          pin_pull;
    logic          vec_fetch;
    logic [AW-1:0] vec_addr;
    logic [4:0]    stat;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    reset_source_ctrl #(
        .POR_CYC (POR_CYC), .PH_CYC (PH_CYC), .PIN_CYC (PIN_CYC), .AW (AW)
    ) dut (
        .clk (clk), .por_n (por_n), .cfg_wdog_off (cfg_wdog_off),
        .cfg_stop_en (cfg_stop_en), .wdog_ovf (wdog_ovf),
        .cpu_bad_op (cpu_bad_op), .cpu_stop_op (cpu_stop_op),
        .bus_cyc (bus_cyc), .bus_opfetch (bus_opfetch), .map_hit (map_hit),
        .ext_rst_n (ext_rst_n), .stat_rd (stat_rd), .core_rst (core_rst),
        .pin_pull (pin_pull), .vec_fetch (vec_fetch), .vec_addr (vec_addr),
        .stat (stat)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle of strobes at a negedge, return at the next negedge
    task automatic fire(input logic w, input logic op, input logic sp,
                        input logic bc, input logic of, input logic mh, input logic ex);
        wdog_ovf = w; cpu_bad_op = op; cpu_stop_op = sp;
        bus_cyc = bc; bus_opfetch = of; map_hit = mh; ext_rst_n = ex;
        @(negedge clk);
        wdog_ovf = 1'b0; cpu_bad_op = 1'b0; cpu_stop_op = 1'b0;
        bus_cyc = 1'b0; bus_opfetch = 1'b0; map_hit = 1'b1; ext_rst_n = 1'b1;
    endtask

    task automatic vec_tail(input string req);
        check(vec_fetch && !core_rst && vec_addr == 16'hFFFE, req, vec_addr, 16'hFFFE);
        @(negedge clk);
        check(vec_fetch && !core_rst && vec_addr == 16'hFFFF, req, vec_addr, 16'hFFFF);
        @(negedge clk);
        check(!vec_fetch && !core_rst, req, vec_fetch, 0);
    endtask

    // called right after fire(): counts cycles with the pin pulled
    task automatic pin_window(input string req);
        int n = 0;
        while (pin_pull && core_rst) begin
            n++;
            @(negedge clk);
        end
        check(n == PIN_CYC, req, n, PIN_CYC);
    endtask

    task automatic no_effect(input string req, input logic [4:0] exp_stat);
        check(!core_rst && !pin_pull, req, core_rst, 0);
        check(stat == exp_stat, req, stat, exp_stat);
    endtask

    task automatic t_por;
        int n = 0;
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        check(stat == 5'b00001, "R1 stat", stat, 5'b00001);
        check(core_rst && !pin_pull, "R1 rst/pin", {core_rst, pin_pull}, 2'b10);
        por_n = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (core_rst && n < POR_CYC + 2 * PH_CYC + 10);
        check(n == POR_CYC + 2 * PH_CYC, "R2 recovery length", n, POR_CYC + 2 * PH_CYC);
        vec_tail("R3 vector after POR");
    endtask

    task automatic t_wdog;
        cfg_wdog_off = 1'b1;
        fire(1, 0, 0, 0, 0, 1, 1);
        no_effect("R4 wdog disabled", 5'b00001);
        cfg_wdog_off = 1'b0;
        fire(1, 0, 0, 0, 0, 1, 1);
        check(stat == 5'b00010, "R4 wdog flag", stat, 5'b00010);
        pin_window("R8 wdog window");
        vec_tail("R3 vector after wdog");
    endtask

    task automatic t_read;
        stat_rd = 1'b1;
        #0;
        check(stat == 5'b00010, "R10 read value", stat, 5'b00010);
        @(negedge clk);
        stat_rd = 1'b0;
        check(stat == 5'b00000, "R10 cleared", stat, 0);
    endtask

    task automatic t_op;
        fire(0, 1, 0, 0, 0, 1, 1);
        check(stat == 5'b00100, "R5 opcode flag", stat, 5'b00100);
        pin_window("R8 opcode window");
        vec_tail("R3 vector after opcode");
    endtask

    task automatic t_stop;
        cfg_stop_en = 1'b1;
        fire(0, 0, 1, 0, 0, 1, 1);
        no_effect("R6 stop allowed", 5'b00100);
        cfg_stop_en = 1'b0;
        fire(0, 0, 1, 0, 0, 1, 1);
        check(stat == 5'b00100 && pin_pull, "R6 stop illegal", stat, 5'b00100);
        pin_window("R8 stop window");
        vec_tail("R3 vector after stop");
        cfg_stop_en = 1'b1;
    endtask

    task automatic t_addr;
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        fire(0, 0, 0, 1, 0, 0, 1);
        no_effect("R7 unmapped data access", 5'b00000);
        fire(0, 0, 0, 1, 1, 1, 1);
        no_effect("R7 mapped opcode fetch", 5'b00000);
        fire(0, 0, 0, 1, 1, 0, 1);
        check(stat == 5'b01000, "R7 unmapped opcode fetch", stat, 5'b01000);
        pin_window("R8 address window");
        vec_tail("R3 vector after address");
    endtask

    task automatic t_ignore;
        int n = 0;
        fire(1, 0, 0, 0, 0, 1, 1);
        repeat (4) begin
            n++;
            @(negedge clk);
        end
        fire(1, 1, 0, 1, 1, 0, 0);
        n++;
        while (pin_pull && core_rst) begin
            n++;
            @(negedge clk);
        end
        check(n == PIN_CYC, "R11 window unchanged", n, PIN_CYC);
        check(stat == 5'b00010, "R11 status unchanged", stat, 5'b00010);
        vec_tail("R11 vector after window");
    endtask

    task automatic t_ext;
        ext_rst_n = 1'b0;
        repeat (6) @(negedge clk);
        check(core_rst && !pin_pull, "R9 held, not pulled", {core_rst, pin_pull}, 2'b10);
        check(stat == 5'b10000, "R9 ext flag", stat, 5'b10000);
        ext_rst_n = 1'b1;
        @(negedge clk);
        vec_tail("R9 vector after ext release");
    endtask

    task automatic t_prio;
        fire(1, 1, 0, 1, 1, 0, 0);
        check(stat == 5'b00010, "R12 wdog first", stat, 5'b00010);
        pin_window("R12 window");
        vec_tail("R12 vector");
        fire(0, 1, 0, 1, 1, 0, 0);
        check(stat == 5'b00100, "R12 opcode over address", stat, 5'b00100);
        pin_window("R12 window");
        vec_tail("R12 vector");
        fire(0, 0, 0, 1, 1, 0, 0);
        check(stat == 5'b01000, "R12 address over ext", stat, 5'b01000);
        pin_window("R12 window");
        vec_tail("R12 vector");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_por();
        t_wdog();
        t_read();
        t_op();
        t_stop();
        t_addr();
        t_ignore();
        t_ext();
        t_prio();
        t_por();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule